// File: doc/BRIEF.md
# Warp Issue Scheduler

This block sits in front of the execution pipes of one scheduler partition. It holds a pool of resident warps, and in every clock cycle it chooses at most one of them whose next instruction may safely go. Each warp has a small scoreboard of destination registers still waiting for a result, plus one flag that marks an outstanding memory access. The instruction buffer offers each warp's next instruction on a set of per-warp ports: a ready bit, the instruction word, two source register indices, an optional destination and a memory-access marker. The scheduler answers within the same cycle with an issue strobe, the chosen warp number and the instruction word.

A warp whose memory access is still outstanding is skipped at once. Every warp keeps its state in place, so a different warp can issue in the very next cycle with no switch penalty. Long memory latency is hidden this way. Writeback and memory-completion ports release the stalled state, and they may arrive any number of cycles later. A launch port turns a warp on after reset.

Top module: `warp_issue_sched`

## Requirements
- R1: In each cycle at most one instruction issues. It issues only when the chosen warp has been launched and its ready bit is high, and `issue_instr` carries that warp's instruction word.
- R2: A warp is not eligible while either source index, or its destination index when `ibuf_has_dst` is 1, equals a register still pending in that warp's scoreboard. Both sources are compared on every instruction.
- R3: A warp with an outstanding memory access is not eligible.
- R4: Issuing an instruction with `ibuf_is_mem` = 1 sets the warp's memory flag at that clock edge. In the next cycle another eligible warp may issue, with no idle cycle in between.
- R5: A writeback for (warp, register) clears that pending entry at the clock edge. The new state is first used in the following cycle, and there is no same-cycle bypass.
- R6: A memory completion for a warp clears its flag at the clock edge, however long after the access it arrives. If it coincides with a new memory issue by the same warp, the issue wins.
- R7: Selection is round-robin. The search starts at the warp after the last one issued and wraps around. After reset the search starts at warp 0.
- R8: When no warp is eligible, `issue_valid` is 0 and no scoreboard, flag or priority state changes.
- R9: Reset empties every scoreboard, clears every memory flag and marks all warps inactive. A launch makes a warp active from the next cycle.
- R10: Each warp tracks up to SB_DEPTH pending destinations. With all of them in use, an instruction that writes a register is blocked, while one with `ibuf_has_dst` = 0 can still issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| launch_valid | input | 1 | Activate the warp named by launch_warp |
| launch_warp | input | WID_W | Warp to activate |
| ibuf_valid | input | NUM_WARPS | Per-warp next-instruction ready |
| ibuf_instr | input | NUM_WARPS*INSTR_W | Per-warp instruction words, warp w at bits w*INSTR_W |
| ibuf_src_a | input | NUM_WARPS*REG_W | Per-warp first source register |
| ibuf_src_b | input | NUM_WARPS*REG_W | Per-warp second source register |
| ibuf_dst | input | NUM_WARPS*REG_W | Per-warp destination register |
| ibuf_has_dst | input | NUM_WARPS | Instruction writes a register |
| ibuf_is_mem | input | NUM_WARPS | Instruction is a memory access |
| wb_valid | input | 1 | Result writeback strobe |
| wb_warp | input | WID_W | Warp of the writeback |
| wb_reg | input | REG_W | Register written back |
| mem_done_valid | input | 1 | Memory completion strobe |
| mem_done_warp | input | WID_W | Warp whose access completed |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp | output | WID_W | Issuing warp |
| issue_instr | output | INSTR_W | Issued instruction word, zero when idle |

## Verification
The properties assume that a memory completion names a warp whose flag is set, or else one that is issuing a memory access in the same cycle. They also assume that launches come one per cycle. The bench only sends completions for warps that its reference model shows as pending, and it only sends writebacks for registers taken from the model's pending list. Completion delays range from a few cycles to several hundred. The random phase draws sources and destinations from a small register range so that hazards, full scoreboards and coinciding writeback and issue events all occur often.

// File: rtl/warp_sched_pkg.sv
// Shared defaults and helpers for the warp issue scheduler.
package warp_sched_pkg;
    localparam int DEF_WARPS    = 16;
    localparam int DEF_INSTR_W  = 32;
    localparam int DEF_REG_W    = 6;
    localparam int DEF_SB_DEPTH = 4;

    // Index reached by stepping 'offset' places after 'base' in a ring of n.
    function automatic int ring_step(input int base, input int offset, input int n);
        return (base + offset) % n;
    endfunction
endpackage

// File: rtl/warp_scoreboard.sv
// Per-warp hazard state: a small table of pending destination registers
// plus one outstanding-memory flag.
// Assumes: alloc is asserted only when full is low; a writeback names at most
// one valid slot, since a duplicate destination is never allocated.
module warp_scoreboard #(
    parameter int REG_W    = warp_sched_pkg::DEF_REG_W,
    parameter int SB_DEPTH = warp_sched_pkg::DEF_SB_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  logic [REG_W-1:0] dst,
    input  logic             has_dst,
    input  logic             alloc,
    input  logic             wb_clr,
    input  logic [REG_W-1:0] wb_reg,
    input  logic             set_mem,
    input  logic             clr_mem,
    output logic             hazard,
    output logic             full,
    output logic             mem_pend
);
    localparam int SLOT_W = (SB_DEPTH > 1) ? $clog2(SB_DEPTH) : 1;

    logic [SB_DEPTH-1:0] slot_vld;
    logic [REG_W-1:0]    slot_reg [SB_DEPTH];
    logic [SB_DEPTH-1:0] slot_hit;
    logic [SB_DEPTH-1:0] slot_clr;
    logic [SLOT_W-1:0]   free_idx;

    // Per-slot comparators against the candidate instruction and writeback.
    for (genvar g = 0; g < SB_DEPTH; g++) begin : g_slot
        assign slot_hit[g] = slot_vld[g] &&
                             ((slot_reg[g] == src_a) || (slot_reg[g] == src_b) ||
                              (has_dst && (slot_reg[g] == dst)));
        assign slot_clr[g] = wb_clr && slot_vld[g] && (slot_reg[g] == wb_reg);
    end

    assign hazard = |slot_hit;
    assign full   = &slot_vld;

    // Lowest free slot receives the next allocation.
    always_comb begin
        free_idx = '0;
        for (int i = SB_DEPTH - 1; i >= 0; i--) begin
            if (!slot_vld[i]) free_idx = SLOT_W'(i);
        end
    end

    // Slot table update: allocate on issue, release on writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld <= '0;
            for (int i = 0; i < SB_DEPTH; i++) slot_reg[i] <= '0;
        end else begin
            for (int i = 0; i < SB_DEPTH; i++) begin
                if (alloc && !full && (free_idx == SLOT_W'(i))) begin
                    slot_vld[i] <= 1'b1;
                    slot_reg[i] <= dst;
                end else if (slot_clr[i]) begin
                    slot_vld[i] <= 1'b0;
                end
            end
        end
    end

    // Outstanding-memory flag: a new access wins over a completion.
    always_ff @(posedge clk) begin
        if (!rst_n)       mem_pend <= 1'b0;
        else if (set_mem) mem_pend <= 1'b1;
        else if (clr_mem) mem_pend <= 1'b0;
    end
endmodule

// File: rtl/warp_rr_arbiter.sv
// Round-robin pick among request bits, searching from the entry after 'last'.
// Assumes: last is below N. Purely combinational.
module warp_rr_arbiter #(
    parameter int N     = warp_sched_pkg::DEF_WARPS,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] last,
    output logic             gnt_valid,
    output logic [IDX_W-1:0] gnt_idx
);
    // First requesting entry in ring order after 'last'.
    always_comb begin
        int idx;
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = 1; k <= N; k++) begin
            idx = warp_sched_pkg::ring_step(int'(last), k, N);
            if (!gnt_valid && req[idx]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IDX_W'(idx);
            end
        end
    end
endmodule

// File: rtl/warp_issue_sched.sv
// Warp issue scheduler: one scoreboard per resident warp, a round-robin
// arbiter over eligible warps, and same-cycle issue of the chosen word.
// Assumes: the instruction buffer holds a warp's word until it issues;
// at most one launch, writeback and completion per cycle.
module warp_issue_sched #(
    parameter int NUM_WARPS = warp_sched_pkg::DEF_WARPS,
    parameter int INSTR_W   = warp_sched_pkg::DEF_INSTR_W,
    parameter int REG_W     = warp_sched_pkg::DEF_REG_W,
    parameter int SB_DEPTH  = warp_sched_pkg::DEF_SB_DEPTH,
    parameter int WID_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           launch_valid,
    input  logic [WID_W-1:0]               launch_warp,
    input  logic [NUM_WARPS-1:0]           ibuf_valid,
    input  logic [NUM_WARPS*INSTR_W-1:0]   ibuf_instr,
    input  logic [NUM_WARPS*REG_W-1:0]     ibuf_src_a,
    input  logic [NUM_WARPS*REG_W-1:0]     ibuf_src_b,
    input  logic [NUM_WARPS*REG_W-1:0]     ibuf_dst,
    input  logic [NUM_WARPS-1:0]           ibuf_has_dst,
    input  logic [NUM_WARPS-1:0]           ibuf_is_mem,
    input  logic                           wb_valid,
    input  logic [WID_W-1:0]               wb_warp,
    input  logic [REG_W-1:0]               wb_reg,
    input  logic                           mem_done_valid,
    input  logic [WID_W-1:0]               mem_done_warp,
    output logic                           issue_valid,
    output logic [WID_W-1:0]               issue_warp,
    output logic [INSTR_W-1:0]             issue_instr
);
    localparam logic [WID_W-1:0] LAST_INIT = WID_W'(NUM_WARPS - 1);

    logic [NUM_WARPS-1:0] active;
    logic [NUM_WARPS-1:0] mem_pend;
    logic [NUM_WARPS-1:0] hazard;
    logic [NUM_WARPS-1:0] sb_full;
    logic [NUM_WARPS-1:0] elig;
    logic [WID_W-1:0]     last_warp;
    logic                 gnt_valid;
    logic [WID_W-1:0]     gnt_idx;

    // One scoreboard and eligibility term per warp.
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        logic picked;
        assign picked = gnt_valid && (gnt_idx == WID_W'(w));

        warp_scoreboard #(.REG_W(REG_W), .SB_DEPTH(SB_DEPTH)) u_sb (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_a   (ibuf_src_a[w*REG_W +: REG_W]),
            .src_b   (ibuf_src_b[w*REG_W +: REG_W]),
            .dst     (ibuf_dst[w*REG_W +: REG_W]),
            .has_dst (ibuf_has_dst[w]),
            .alloc   (picked && ibuf_has_dst[w]),
            .wb_clr  (wb_valid && (wb_warp == WID_W'(w))),
            .wb_reg  (wb_reg),
            .set_mem (picked && ibuf_is_mem[w]),
            .clr_mem (mem_done_valid && (mem_done_warp == WID_W'(w))),
            .hazard  (hazard[w]),
            .full    (sb_full[w]),
            .mem_pend(mem_pend[w])
        );

        assign elig[w] = active[w] && ibuf_valid[w] && !mem_pend[w] &&
                         !hazard[w] && !(ibuf_has_dst[w] && sb_full[w]);
    end

    warp_rr_arbiter #(.N(NUM_WARPS), .IDX_W(WID_W)) u_arb (
        .req      (elig),
        .last     (last_warp),
        .gnt_valid(gnt_valid),
        .gnt_idx  (gnt_idx)
    );

    assign issue_valid = gnt_valid;
    assign issue_warp  = gnt_idx;
    assign issue_instr = gnt_valid ? ibuf_instr[gnt_idx*INSTR_W +: INSTR_W] : '0;

    // Residency: warps become active only through the launch port.
    always_ff @(posedge clk) begin
        if (!rst_n)            active <= '0;
        else if (launch_valid) active[launch_warp] <= 1'b1;
    end

    // Round-robin pointer follows the last issued warp.
    always_ff @(posedge clk) begin
        if (!rst_n)         last_warp <= LAST_INIT;
        else if (gnt_valid) last_warp <= gnt_idx;
    end
endmodule

// File: rtl/warp_issue_sched_chk.sv
// Property checker for the warp issue scheduler, bound to every instance.
// Assumes: completions arrive only for pending warps or coincide with a new access.
module warp_issue_sched_chk #(
    parameter int NUM_WARPS = 16,
    parameter int WID_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 issue_valid,
    input logic [WID_W-1:0]     issue_warp,
    input logic [NUM_WARPS-1:0] ibuf_valid,
    input logic [NUM_WARPS-1:0] ibuf_is_mem,
    input logic [NUM_WARPS-1:0] ibuf_has_dst,
    input logic [NUM_WARPS-1:0] active,
    input logic [NUM_WARPS-1:0] mem_pend,
    input logic [NUM_WARPS-1:0] elig,
    input logic [NUM_WARPS-1:0] sb_full,
    input logic                 mem_done_valid,
    input logic [WID_W-1:0]     mem_done_warp
);
    assert_issue_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (active[issue_warp] && ibuf_valid[issue_warp]));

    assert_no_issue_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !mem_pend[issue_warp]);

    assert_mem_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && ibuf_is_mem[issue_warp]) |=> mem_pend[$past(issue_warp)]);

    assert_busy_when_eligible_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|elig) |-> issue_valid);

    assert_idle_when_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|elig) |-> !issue_valid);

    assert_full_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && ibuf_has_dst[issue_warp]) |-> !sb_full[issue_warp]);

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_w
        assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_pend[w] && !(mem_done_valid && mem_done_warp == WID_W'(w))) |=> mem_pend[w]);

        assert_flag_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_done_valid && mem_done_warp == WID_W'(w) &&
             !(issue_valid && issue_warp == WID_W'(w) && ibuf_is_mem[w])) |=> !mem_pend[w]);

        assert_stay_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
            active[w] |=> active[w]);
    end
endmodule

bind warp_issue_sched warp_issue_sched_chk #(.NUM_WARPS(NUM_WARPS), .WID_W(WID_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_valid   (issue_valid),
    .issue_warp    (issue_warp),
    .ibuf_valid    (ibuf_valid),
    .ibuf_is_mem   (ibuf_is_mem),
    .ibuf_has_dst  (ibuf_has_dst),
    .active        (active),
    .mem_pend      (mem_pend),
    .elig          (elig),
    .sb_full       (sb_full),
    .mem_done_valid(mem_done_valid),
    .mem_done_warp (mem_done_warp)
);

// File: tb/test_warp_issue_sched.sv
`timescale 1ns/1ps
module test_warp_issue_sched;
    localparam int N  = 16;
    localparam int IW = 32;
    localparam int RW = 6;
    localparam int SD = 4;
    localparam int WW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic launch_valid = 1'b0;
    logic [WW-1:0] launch_warp = '0;
    logic [N-1:0] ibuf_valid;
    logic [N*IW-1:0] ibuf_instr;
    logic [N*RW-1:0] ibuf_src_a, ibuf_src_b, ibuf_dst;
    logic [N-1:0] ibuf_has_dst, ibuf_is_mem;
    logic wb_valid = 1'b0;
    logic [WW-1:0] wb_warp = '0;
    logic [RW-1:0] wb_reg = '0;
    logic mem_done_valid = 1'b0;
    logic [WW-1:0] mem_done_warp = '0;
    logic issue_valid;
    logic [WW-1:0] issue_warp;
    logic [IW-1:0] issue_instr;

    logic [IW-1:0] b_instr [N];
    logic [RW-1:0] b_sa [N], b_sb [N], b_dst [N];
    logic b_v [N], b_hd [N], b_mem [N];

    int errors = 0;
    int checks = 0;
    bit m_active [N];
    bit m_mem [N];
    int m_sb [N][$];
    int m_last;
    bit last_v;
    int last_w;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int w = 0; w < N; w++) begin
            ibuf_valid[w]           = b_v[w];
            ibuf_has_dst[w]         = b_hd[w];
            ibuf_is_mem[w]          = b_mem[w];
            ibuf_instr[w*IW +: IW]  = b_instr[w];
            ibuf_src_a[w*RW +: RW]  = b_sa[w];
            ibuf_src_b[w*RW +: RW]  = b_sb[w];
            ibuf_dst[w*RW +: RW]    = b_dst[w];
        end
    end

    warp_issue_sched #(.NUM_WARPS(N), .INSTR_W(IW), .REG_W(RW), .SB_DEPTH(SD)) i_warp_issue_sched (
        .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_warp(launch_warp),
        .ibuf_valid(ibuf_valid), .ibuf_instr(ibuf_instr), .ibuf_src_a(ibuf_src_a),
        .ibuf_src_b(ibuf_src_b), .ibuf_dst(ibuf_dst), .ibuf_has_dst(ibuf_has_dst),
        .ibuf_is_mem(ibuf_is_mem), .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
        .mem_done_valid(mem_done_valid), .mem_done_warp(mem_done_warp),
        .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_instr(issue_instr));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int w = 0; w < N; w++) begin
            m_active[w] = 0; m_mem[w] = 0; m_sb[w].delete();
        end
        m_last = N - 1;
    endtask

    function automatic bit model_elig(input int w);
        bit hz = 0;
        foreach (m_sb[w][j]) begin
            if (m_sb[w][j] == int'(b_sa[w]) || m_sb[w][j] == int'(b_sb[w]) ||
                (b_hd[w] && m_sb[w][j] == int'(b_dst[w]))) hz = 1;
        end
        return m_active[w] && b_v[w] && !m_mem[w] && !hz && !(b_hd[w] && m_sb[w].size() >= SD);
    endfunction

    // Compare outputs against the model for this cycle, then advance the model.
    task automatic step();
        bit ev = 0;
        int ew = 0;
        #1;
        for (int k = 1; k <= N; k++) begin
            int idx = (m_last + k) % N;
            if (!ev && model_elig(idx)) begin ev = 1; ew = idx; end
        end
        chk(issue_valid == ev, "R1 issue_valid", int'(issue_valid), int'(ev));
        if (ev) begin
            chk(int'(issue_warp) == ew, "R7 issue_warp", int'(issue_warp), ew);
            chk(issue_instr == b_instr[ew], "R1 issue_instr", int'(issue_instr), int'(b_instr[ew]));
        end
        last_v = issue_valid;
        last_w = int'(issue_warp);
        if (wb_valid) begin
            for (int j = m_sb[wb_warp].size() - 1; j >= 0; j--)
                if (m_sb[wb_warp][j] == int'(wb_reg)) m_sb[wb_warp].delete(j);
        end
        if (mem_done_valid) m_mem[mem_done_warp] = 0;
        if (ev) begin
            if (b_hd[ew]) m_sb[ew].push_back(int'(b_dst[ew]));
            if (b_mem[ew]) m_mem[ew] = 1;
            m_last = ew;
        end
        if (launch_valid) m_active[launch_warp] = 1;
        @(negedge clk);
    endtask

    task automatic set_ins(input int w, input bit v, input int sa, input int sb,
                           input int dst, input bit hd, input bit mem);
        b_v[w] = v; b_sa[w] = RW'(sa); b_sb[w] = RW'(sb); b_dst[w] = RW'(dst);
        b_hd[w] = hd; b_mem[w] = mem; b_instr[w] = IW'($urandom);
    endtask

    task automatic launch(input int w);
        launch_valid = 1; launch_warp = WW'(w);
        step();
        launch_valid = 0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int cnt;
        for (int w = 0; w < N; w++) set_ins(w, 0, 0, 0, 0, 0, 0);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R9: nothing issues after reset, even with every buffer ready.
        for (int w = 0; w < N; w++) set_ins(w, 1, 0, 0, 0, 0, 0);
        step(); chk(last_v == 0, "R9 reset idle", int'(last_v), 0);
        step(); chk(last_v == 0, "R9 reset idle", int'(last_v), 0);
        for (int w = 0; w < N; w++) b_v[w] = 0;

        launch(0); launch(1); launch(2);
        for (int w = 0; w < 3; w++) set_ins(w, 1, 0, 0, 0, 0, 0);
        // R7: ring order from warp 0 after reset.
        step(); chk(last_v && last_w == 0, "R7 first pick", last_w, 0);
        step(); chk(last_v && last_w == 1, "R7 ring order", last_w, 1);
        step(); chk(last_v && last_w == 2, "R7 ring order", last_w, 2);
        step(); chk(last_v && last_w == 0, "R7 wrap", last_w, 0);

        // R4/R3/R6: memory access on warp 0 with a long completion delay.
        set_ins(0, 1, 0, 0, 0, 0, 1);
        step(); step();
        step(); chk(last_v && last_w == 0, "R4 mem issue", last_w, 0);
        set_ins(0, 1, 0, 0, 0, 0, 0);
        step(); chk(last_v && last_w == 1, "R4 no switch gap", last_w, 1);
        cnt = 0;
        for (int c = 0; c < 300; c++) begin
            step();
            if (last_v && last_w == 0) cnt++;
        end
        chk(cnt == 0, "R3 pending skip", cnt, 0);
        mem_done_valid = 1; mem_done_warp = 0;
        step();
        mem_done_valid = 0;
        cnt = 0;
        for (int c = 0; c < 3; c++) begin
            step();
            if (last_v && last_w == 0) cnt++;
        end
        chk(cnt == 1, "R6 completion releases", cnt, 1);

        // R2/R5/R8: register dependency on warp 1 only.
        b_v[0] = 0; b_v[2] = 0;
        set_ins(1, 1, 0, 0, 5, 1, 0);
        step(); chk(last_v && last_w == 1, "R2 producer issues", last_w, 1);
        set_ins(1, 1, 3, 5, 0, 0, 0);
        step(); chk(last_v == 0, "R2 source hazard", int'(last_v), 0);
        step(); chk(last_v == 0, "R8 idle cycle", int'(last_v), 0);
        wb_valid = 1; wb_warp = 1; wb_reg = 5;
        step(); chk(last_v == 0, "R5 no bypass", int'(last_v), 0);
        wb_valid = 0;
        step(); chk(last_v && last_w == 1, "R5 after writeback", last_w, 1);
        b_v[1] = 0;

        // R10: fill warp 2's scoreboard.
        for (int d = 1; d <= SD; d++) begin
            set_ins(2, 1, 0, 0, d, 1, 0);
            step(); chk(last_v && last_w == 2, "R10 fill", last_w, 2);
        end
        set_ins(2, 1, 0, 0, 9, 1, 0);
        step(); chk(last_v == 0, "R10 full blocks", int'(last_v), 0);
        set_ins(2, 1, 0, 0, 0, 0, 0);
        step(); chk(last_v && last_w == 2, "R10 no-dst passes", last_w, 2);
        b_v[2] = 0;
        for (int d = 1; d <= SD; d++) begin
            wb_valid = 1; wb_warp = 2; wb_reg = RW'(d);
            step();
        end
        wb_valid = 0;

        // Random phase over the whole pool.
        for (int w = 3; w < N; w++) launch(w);
        for (int c = 0; c < 3000; c++) begin
            for (int w = 0; w < N; w++)
                set_ins(w, $urandom_range(0, 9) < 7, $urandom_range(0, 7), $urandom_range(0, 7),
                        $urandom_range(1, 7), $urandom_range(0, 1) == 1, $urandom_range(0, 7) == 0);
            begin
                int w = $urandom_range(0, N - 1);
                wb_valid = 0;
                if (m_sb[w].size() > 0 && $urandom_range(0, 1) == 1) begin
                    wb_valid = 1; wb_warp = WW'(w);
                    wb_reg = RW'(m_sb[w][$urandom_range(0, m_sb[w].size() - 1)]);
                end
            end
            begin
                int w = $urandom_range(0, N - 1);
                mem_done_valid = 0;
                if (m_mem[w] && $urandom_range(0, 39) == 0) begin
                    mem_done_valid = 1; mem_done_warp = WW'(w);
                end
            end
            step();
        end
        wb_valid = 0; mem_done_valid = 0;

        // R9: second reset clears residency; launch re-enables one warp.
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();
        for (int w = 0; w < N; w++) set_ins(w, 1, 0, 0, 0, 0, 0);
        step(); chk(last_v == 0, "R9 all inactive", int'(last_v), 0);
        launch(5); chk(last_v == 0, "R9 launch latency", int'(last_v), 0);
        step(); chk(last_v && last_w == 5, "R9 launched warp", last_w, 5);
        finish_run();
    end
endmodule